// File: doc/BRIEF.md
# Floating-Point / Integer Register Bit Transfer Unit

This unit moves the raw bit pattern of a floating-point value between a 64-bit floating-point register value and a 64-bit integer register value, in either direction. A direction input selects the path. A two-bit mode field chooses between double handling and single handling, and decides whether a condition-register field is produced. In double handling the 64 bits pass through untouched. In single handling the value is repacked exactly, with no rounding.

When moving toward the integer side, a double is narrowed to a 32-bit single pattern, the same way a single-precision store would do it. The pattern lands in the low half of the result and the upper half is zero. When moving toward the floating-point side, the low 32 bits of the source are read as a single pattern and widened to a double, the same way a single-precision load would do it. Single denormals are normalised during this step.

One operation is accepted per cycle. Its result appears one clock later, together with a condition value and a write enable for it. Toward the integer side the condition value is a signed test of the 64-bit result. Toward the floating-point side it is built from floating-point status bits that arrive on a sideband input. No floating-point status is ever produced or changed.

Top module: `fpgpr_xfer`

## Requirements
- R1: While reset is asserted and after its release, before any operation is accepted, `res_valid`, `cond_we`, `res_word` and `cond_val` are all zero.
- R2: An operation accepted with `op_valid`=1 at a rising edge gives its result at the next rising edge, with `res_valid`=1. `mode[1]`=1 selects single handling and `mode[0]`=1 selects a condition update. `cond_we` is 1 exactly when the result belongs to an operation whose `mode[0]` was 1.
- R3: With `mode[1]`=0 the destination word equals the 64-bit source, unchanged, for both values of `to_fp`.
- R4: With `to_fp`=0 and `mode[1]`=1, bits 63:32 of the result are zero. If the source exponent (bits 62:52) is 0 or above 896, bits 31:0 hold {sign, exp[10], exp[6:0], frac[51:29]}. This keeps the class of zero, infinity and NaN, and it truncates the fraction rather than rounding it.
- R5: With `to_fp`=0 and `mode[1]`=1, if the source exponent e lies in 1..896, bits 31:0 hold the sign followed by eight zero exponent bits. The 23 fraction bits are the hidden one and the fraction, shifted right by 897-e and truncated. An exponent below 874 therefore gives a signed zero.
- R6: With `to_fp`=1 and `mode[1]`=1, a nonzero single exponent s in 1..254 becomes double exponent s+896. Exponent 255 becomes 0x7FF. A zero single exponent with a zero fraction gives a signed zero. In every one of these cases the 23 fraction bits are placed at double bits 51:29, with zeros below them. Bits 63:32 of the source are ignored.
- R7: With `to_fp`=1 and `mode[1]`=1, a single denormal (exponent 0, fraction nonzero) becomes the normal double of the same value: exponent 896 minus the count of leading zeros in the 23-bit fraction, and the bits below the leading one left-aligned in the fraction.
- R8: With `to_fp`=0, the condition value is {LT, GT, EQ, SO} on bits 3..0. LT, GT and EQ come from a signed comparison of the 64-bit result with zero, and SO copies `ovf_in`.
- R9: With `to_fp`=1, the condition value equals `fp_flags`, taken as {FX, FEX, VX, OX} on bits 3..0.
- R10: A cycle with `op_valid`=0 leaves `res_word` and `cond_val` unchanged, and gives `res_valid`=0 and `cond_we`=0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation accepted this cycle |
| to_fp | input | 1 | 1: integer to floating point; 0: floating point to integer |
| mode | input | 2 | Bit 1 single handling, bit 0 condition update |
| src_word | input | 64 | Source register value |
| fp_flags | input | 4 | Sideband {FX, FEX, VX, OX} for the floating-point condition |
| ovf_in | input | 1 | Summary overflow bit for the integer condition |
| res_valid | output | 1 | Result of last cycle's operation is present |
| res_word | output | 64 | Destination register value |
| cond_val | output | 4 | Condition field value |
| cond_we | output | 1 | Condition field write enable |

## Verification
Narrowing is exercised with normal values, with fraction bits placed just below and just at the truncation point, and with infinity, NaN and signed zero. It is also given exponents at the top, the middle, the lowest edge and just under the single-denormal band, which separates a correct shift count from an off-by-one. Widening is given normal values whose upper source half carries junk, to show that half is ignored. It is also given infinity, a NaN with payload, and denormals with the leading one at the top, middle and bottom of the fraction, which tests the normaliser's count. Double copies in both directions, negative, zero and positive integer results, and idle cycles tell the condition encodings, the enable and the hold behaviour apart.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned SGL_W   = 32;
  localparam int unsigned DEXP_W  = 11;
  localparam int unsigned DFRAC_W = 52;
  localparam int unsigned SEXP_W  = 8;
  localparam int unsigned SFRAC_W = 23;
  localparam int unsigned CR_W    = 4;
  localparam int unsigned FRAC_GAP = DFRAC_W - SFRAC_W;       // 29
  localparam int unsigned BIAS_GAP = 1023 - 127;             // 896

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_int_t;

  // leading zero count of a single-precision fraction
  function automatic logic [4:0] lead_zeros23(input logic [SFRAC_W-1:0] v);
    logic [4:0] n;
    logic       hit;
    n   = 5'd0;
    hit = 1'b0;
    for (int i = SFRAC_W - 1; i >= 0; i--) begin
      if (!hit && v[i]) hit = 1'b1;
      else if (!hit)    n = n + 5'd1;
    end
    return n;
  endfunction
endpackage

// File: rtl/fpx_narrow.sv
module fpx_narrow
  import fpx_pkg::*;
(
  input  logic [WORD_W-1:0] dbl,
  output logic [SGL_W-1:0]  sgl
);
  localparam int unsigned SH_W = DEXP_W;

  logic                 sgn;
  logic [DEXP_W-1:0]    ex;
  logic [DFRAC_W-1:0]   fr;
  logic [DFRAC_W:0]     mant;
  logic [DFRAC_W:0]     mant_sh;
  logic [SH_W-1:0]      sh_amt;
  logic                 direct_map;

  always_comb begin
    sgn        = dbl[WORD_W-1];
    ex         = dbl[WORD_W-2 -: DEXP_W];
    fr         = dbl[DFRAC_W-1:0];
    mant       = {1'b1, fr};
    direct_map = (ex == '0) || (ex > DEXP_W'(BIAS_GAP));
    sh_amt     = SH_W'(BIAS_GAP + 1) - ex;
    mant_sh    = mant >> sh_amt;
    if (direct_map)
      sgl = {sgn, ex[DEXP_W-1], ex[SEXP_W-2:0], fr[DFRAC_W-1 -: SFRAC_W]};
    else
      sgl = {sgn, {SEXP_W{1'b0}}, mant_sh[DFRAC_W-1 -: SFRAC_W]};
  end

  // infinity and NaN sources must keep an all-ones single exponent
  always_comb begin
    if (ex == '1)
      AST_NARROW_SPECIAL: assert (sgl[SGL_W-2 -: SEXP_W] == '1); // R4
  end
endmodule

// File: rtl/fpx_widen.sv
module fpx_widen
  import fpx_pkg::*;
(
  input  logic [SGL_W-1:0]  sgl,
  output logic [WORD_W-1:0] dbl
);
  logic                 sgn;
  logic [SEXP_W-1:0]    ex;
  logic [SFRAC_W-1:0]   fr;
  logic [4:0]           lz;
  logic [DFRAC_W-1:0]   fr_wide;
  logic [DFRAC_W-1:0]   fr_norm;
  logic [DEXP_W-1:0]    ex_norm;

  always_comb begin
    sgn     = sgl[SGL_W-1];
    ex      = sgl[SGL_W-2 -: SEXP_W];
    fr      = sgl[SFRAC_W-1:0];
    fr_wide = {fr, {FRAC_GAP{1'b0}}};
    lz      = lead_zeros23(fr);
    fr_norm = fr_wide << (lz + 5'd1);
    ex_norm = DEXP_W'(BIAS_GAP) - DEXP_W'(lz);
    if (ex == '0 && fr == '0)
      dbl = {sgn, {(WORD_W-1){1'b0}}};
    else if (ex == '0)
      dbl = {sgn, ex_norm, fr_norm};
    else if (ex == '1)
      dbl = {sgn, {DEXP_W{1'b1}}, fr_wide};
    else
      dbl = {sgn, ex[SEXP_W-1], {3{~ex[SEXP_W-1]}}, ex[SEXP_W-2:0], fr_wide};
  end

  // a nonzero single never collapses to a zero or denormal double exponent
  always_comb begin
    if (sgl[SGL_W-2:0] != '0)
      AST_WIDEN_NONZERO: assert (dbl[WORD_W-2 -: DEXP_W] != '0); // R7
  end
endmodule

// File: rtl/fpx_crgen.sv
module fpx_crgen
  import fpx_pkg::*;
(
  input  logic              to_fp,
  input  logic [WORD_W-1:0] result,
  input  logic              ovf_in,
  input  logic [CR_W-1:0]   fp_flags,
  output logic [CR_W-1:0]   cr
);
  cr_int_t ic;

  always_comb begin
    ic.lt = result[WORD_W-1];
    ic.eq = (result == '0);
    ic.gt = !result[WORD_W-1] && (result != '0);
    ic.so = ovf_in;
    cr    = to_fp ? fp_flags : ic;
  end

  always_comb begin
    if (!to_fp)
      AST_CR0_ONE_HOT: assert ($countones(cr[CR_W-1:1]) == 1); // R8
  end
endmodule

// File: rtl/fpgpr_xfer.sv
module fpgpr_xfer
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              to_fp,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] src_word,
  input  logic [CR_W-1:0]   fp_flags,
  input  logic              ovf_in,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic [CR_W-1:0]   cond_val,
  output logic              cond_we
);
  logic [SGL_W-1:0]  nar_out;
  logic [WORD_W-1:0] wid_out;
  logic [WORD_W-1:0] mux_out;
  logic [CR_W-1:0]   cr_calc;
  logic              single_sel;

  logic [WORD_W-1:0] word_d;
  logic [CR_W-1:0]   cr_d;
  logic              vld_d, we_d;

  fpx_narrow u_narrow (
    .dbl (src_word),
    .sgl (nar_out)
  );

  fpx_widen u_widen (
    .sgl (src_word[SGL_W-1:0]),
    .dbl (wid_out)
  );

  always_comb begin
    single_sel = mode[1];
    if (!single_sel)  mux_out = src_word;
    else if (to_fp)   mux_out = wid_out;
    else              mux_out = {{(WORD_W-SGL_W){1'b0}}, nar_out};
  end

  fpx_crgen u_crgen (
    .to_fp    (to_fp),
    .result   (mux_out),
    .ovf_in   (ovf_in),
    .fp_flags (fp_flags),
    .cr       (cr_calc)
  );

  // next state: registers load only on an accepted operation
  always_comb begin
    word_d = res_word;
    cr_d   = cond_val;
    vld_d  = op_valid;
    we_d   = op_valid && mode[0];
    if (op_valid) begin
      word_d = mux_out;
      cr_d   = cr_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_word  <= '0;
      cond_val  <= '0;
      res_valid <= 1'b0;
      cond_we   <= 1'b0;
    end else begin
      res_word  <= word_d;
      cond_val  <= cr_d;
      res_valid <= vld_d;
      cond_we   <= we_d;
    end
  end

  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cond_we |-> res_valid); // R2

  AST_DOUBLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !mode[1]) |=> (res_word == $past(src_word))); // R3

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !to_fp && mode[1]) |=> (res_word[WORD_W-1:SGL_W] == '0)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_word) && $stable(cond_val) && !res_valid)); // R10

  AST_FP_COND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && to_fp) |=> (cond_val == $past(fp_flags))); // R9
endmodule

// File: tb/fpgpr_xfer_bench.sv
module fpgpr_xfer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        to_fp;
  logic [1:0]  mode;
  logic [63:0] src_word;
  logic [3:0]  fp_flags;
  logic        ovf_in;
  logic        res_valid;
  logic [63:0] res_word;
  logic [3:0]  cond_val;
  logic        cond_we;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fpgpr_xfer u_fpgpr_xfer (
    .clk, .rst_n, .op_valid, .to_fp, .mode, .src_word,
    .fp_flags, .ovf_in, .res_valid, .res_word, .cond_val, .cond_we
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one op, sample one edge later, check word/cond/we/valid
  task automatic run_op(input string req, input logic dir, input logic [1:0] md,
                        input logic [63:0] src, input logic [3:0] flg, input logic so,
                        input logic [63:0] exp_word, input logic [3:0] exp_cr);
    @(negedge clk);
    op_valid = 1'b1; to_fp = dir; mode = md; src_word = src;
    fp_flags = flg; ovf_in = so;
    @(negedge clk);
    op_valid = 1'b0;
    chk(req, res_word, exp_word);
    chk({req, " valid R2"}, {63'd0, res_valid}, 64'd1);
    chk({req, " we R2"}, {63'd0, cond_we}, {63'd0, md[0]});
    if (md[0]) chk({req, " cond"}, {60'd0, cond_val}, {60'd0, exp_cr});
  endtask

  task automatic t_reset();
    chk("R1 word", res_word, 64'd0);
    chk("R1 cond", {60'd0, cond_val}, 64'd0);
    chk("R1 valid", {63'd0, res_valid}, 64'd0);
    chk("R1 we", {63'd0, cond_we}, 64'd0);
  endtask

  task automatic t_double_copy();
    run_op("R3 f2i", 1'b0, 2'd0, 64'h400921FB54442D18, 4'h0, 1'b0, 64'h400921FB54442D18, 4'h0);
    run_op("R3 i2f", 1'b1, 2'd0, 64'hDEADBEEF01234567, 4'h0, 1'b0, 64'hDEADBEEF01234567, 4'h0);
  endtask

  task automatic t_narrow_normal();
    run_op("R4 one", 1'b0, 2'd2, 64'h3FF0000000000000, 4'h0, 1'b0, 64'h3F800000, 4'h0);
    run_op("R4 trunc below", 1'b0, 2'd2, 64'h3FF0000010000000, 4'h0, 1'b0, 64'h3F800000, 4'h0);
    run_op("R4 trunc at", 1'b0, 2'd2, 64'h3FF0000020000000, 4'h0, 1'b0, 64'h3F800001, 4'h0);
    run_op("R4 inf", 1'b0, 2'd2, 64'h7FF0000000000000, 4'h0, 1'b0, 64'h7F800000, 4'h0);
    run_op("R4 nan", 1'b0, 2'd2, 64'h7FF8000000000001, 4'h0, 1'b0, 64'h7FC00000, 4'h0);
    run_op("R4 negzero", 1'b0, 2'd2, 64'h8000000000000000, 4'h0, 1'b0, 64'h80000000, 4'h0);
  endtask

  task automatic t_narrow_denorm();
    run_op("R5 top", 1'b0, 2'd2, 64'h3800000000000000, 4'h0, 1'b0, 64'h00400000, 4'h0);
    run_op("R5 frac", 1'b0, 2'd2, 64'h37F8000000000000, 4'h0, 1'b0, 64'h00300000, 4'h0);
    run_op("R5 neg", 1'b0, 2'd2, 64'hB800000000000000, 4'h0, 1'b0, 64'h80400000, 4'h0);
    run_op("R5 lowest", 1'b0, 2'd2, 64'h36A0000000000000, 4'h0, 1'b0, 64'h00000001, 4'h0);
    run_op("R5 under", 1'b0, 2'd2, 64'h3690000000000000, 4'h0, 1'b0, 64'h00000000, 4'h0);
  endtask

  task automatic t_widen_normal();
    run_op("R6 one", 1'b1, 2'd2, 64'hFFFFFFFF3F800000, 4'h0, 1'b0, 64'h3FF0000000000000, 4'h0);
    run_op("R6 neg", 1'b1, 2'd2, 64'h12345678C0200000, 4'h0, 1'b0, 64'hC004000000000000, 4'h0);
    run_op("R6 inf", 1'b1, 2'd2, 64'h000000007F800000, 4'h0, 1'b0, 64'h7FF0000000000000, 4'h0);
    run_op("R6 nan", 1'b1, 2'd2, 64'h000000007FC00001, 4'h0, 1'b0, 64'h7FF8000020000000, 4'h0);
    run_op("R6 negzero", 1'b1, 2'd2, 64'hAAAAAAAA80000000, 4'h0, 1'b0, 64'h8000000000000000, 4'h0);
  endtask

  task automatic t_widen_denorm();
    run_op("R7 top", 1'b1, 2'd2, 64'h0000000000400000, 4'h0, 1'b0, 64'h3800000000000000, 4'h0);
    run_op("R7 mid", 1'b1, 2'd2, 64'h0000000080300000, 4'h0, 1'b0, 64'hB7F8000000000000, 4'h0);
    run_op("R7 bottom", 1'b1, 2'd2, 64'h0000000000000001, 4'h0, 1'b0, 64'h36A0000000000000, 4'h0);
  endtask

  task automatic t_cond_int();
    run_op("R8 lt", 1'b0, 2'd1, 64'h8000000000000001, 4'h0, 1'b0, 64'h8000000000000001, 4'b1000);
    run_op("R8 gt so", 1'b0, 2'd3, 64'hC004000000000000, 4'h0, 1'b1, 64'h00000000C0200000, 4'b0101);
    run_op("R8 eq", 1'b0, 2'd3, 64'h0000000000000000, 4'h0, 1'b0, 64'h0, 4'b0010);
  endtask

  task automatic t_cond_fp();
    run_op("R9 flags", 1'b1, 2'd3, 64'h000000003F800000, 4'b1010, 1'b1, 64'h3FF0000000000000, 4'b1010);
    run_op("R9 dbl", 1'b1, 2'd1, 64'h0123456789ABCDEF, 4'b0101, 1'b0, 64'h0123456789ABCDEF, 4'b0101);
  endtask

  task automatic t_idle_hold();
    run_op("R10 setup", 1'b0, 2'd1, 64'h0000000000000005, 4'h0, 1'b0, 64'h5, 4'b0100);
    @(negedge clk);
    op_valid = 1'b0; to_fp = 1'b1; mode = 2'd3; src_word = 64'hFFFF0000FFFF0000;
    fp_flags = 4'hF; ovf_in = 1'b1;
    @(negedge clk);
    chk("R10 word", res_word, 64'h5);
    chk("R10 cond", {60'd0, cond_val}, 64'b0100);
    chk("R10 valid", {63'd0, res_valid}, 64'd0);
    chk("R10 we", {63'd0, cond_we}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; to_fp = 1'b0; mode = 2'd0;
    src_word = '0; fp_flags = '0; ovf_in = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_double_copy();
    t_narrow_normal();
    t_narrow_denorm();
    t_widen_normal();
    t_widen_denorm();
    t_cond_int();
    t_cond_fp();
    t_idle_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule